// File: doc/BRIEF.md
# Vectored Interrupt Message Controller

The block gathers 64 interrupt lines and turns each pending, permitted line into a single message for an upstream vector controller. Software sets each line's trigger style (edge or level) and its sense (high/rising or low/falling) in two independent bit fields. Every line also owns a programmable vector byte and a route byte, which travel with its message. Lines are synchronised with two flops before any detection takes place.

A pending line stays latched until software writes a one to its bit in the clear field. Each pending period yields at most one message. When more than one line is eligible, the lowest-numbered line wins. The output is a valid/ready channel. Once `msg_valid` is high, it stays high and `msg_vector`/`msg_route` stay frozen until the consumer raises `msg_ready` on a clock edge. The next message may be presented in the cycle that follows that handshake. The register port is a plain synchronous write with combinational read data. Accesses are word-aligned, and each byte enable guards one byte lane.

Top module: `vmc_top`

## Requirements
- R1: Each 64-bit control field spans two 32-bit words at consecutive word addresses. Line n sits in word n/32 at bit n%32. A write changes only the byte lanes whose byte enable is set, and a read returns the stored word.
- R2: The mask field (word offset 0x20) blocks a line from sending while its bit is 1. It allows the line to send while its bit is 0.
- R3: The message-enable field (offset 0x40) allows a line to send only while its bit is 1.
- R4: The trigger field (offset 0x60) selects edge detection with a 1 and level detection with a 0. The sense field (offset 0x3E0) selects rising/high with a 0 and falling/low with a 1. All four combinations latch pending on the matching condition only.
- R5: The clear field (offset 0x80) is write-one-to-clear and reads as zero. Writing a 0 bit has no effect. Pending stays latched after a level input goes inactive, and also while the line is masked.
- R6: Line n's message carries the vector byte at address 0x200+n and the route byte at 0x100+n. Byte n sits in lane n%4 of its word.
- R7: A pending line sends exactly one message per pending period. A clear re-arms the line. When a clear and a new trigger condition land in the same cycle, the line stays pending and sends again.
- R8: Among eligible lines, the lowest index is sent first.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_vector` and `msg_route` hold unchanged.
- R10: The words at 0xC0 and 0xE0 store and read back what was written, and have no effect on messages.
- R11: After reset, mask, enable, trigger, sense, vector and route are zero, no line is pending, and `msg_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Asynchronous interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables for a write |
| reg_rdata | output | 32 | Read data for reg_addr |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts message |
| msg_vector | output | 8 | Vector byte of the message |
| msg_route | output | 8 | Route byte of the message |

## Verification
The delicate overlap is a clear write that lands in the same cycle as a fresh trigger condition on the same line. The clear would drop pending, while the trigger would set it again. The bench provokes this by holding a level-high line active after its message has been accepted, and then writing its clear bit: the clear and the re-latch must coincide. The outcome is judged at the output: a second message with the same vector and route must appear. A zero-valued clear write must produce no message at all.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  localparam int OFS_MASK  = 'h20;
  localparam int OFS_EN    = 'h40;
  localparam int OFS_EDGE  = 'h60;
  localparam int OFS_CLR   = 'h80;
  localparam int OFS_AUX0  = 'hC0;
  localparam int OFS_AUX1  = 'hE0;
  localparam int OFS_ROUTE = 'h100;
  localparam int OFS_VEC   = 'h200;
  localparam int OFS_POL   = 'h3E0;

  localparam int F_MASK = 0;
  localparam int F_EN   = 1;
  localparam int F_EDGE = 2;
  localparam int F_POL  = 3;
  localparam int F_AUX0 = 4;
  localparam int F_AUX1 = 5;
  localparam int NFLD   = 6;

  function automatic int fld_base(input int f);
    case (f)
      F_MASK:  return OFS_MASK;
      F_EN:    return OFS_EN;
      F_EDGE:  return OFS_EDGE;
      F_POL:   return OFS_POL;
      F_AUX0:  return OFS_AUX0;
      default: return OFS_AUX1;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] be_merge(input logic [31:0] old_w,
                                           input logic [31:0] new_w,
                                           input logic [3:0]  be);
    return (old_w & ~lane_mask(be)) | (new_w & lane_mask(be));
  endfunction
endpackage

// File: rtl/vmc_regs.sv
module vmc_regs
  import vmc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int AW   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  output logic [31:0]       rdata,
  output logic [NSRC-1:0]   mask,
  output logic [NSRC-1:0]   enable,
  output logic [NSRC-1:0]   edge_mode,
  output logic [NSRC-1:0]   active_low,
  output logic [NSRC-1:0]   clr,
  output logic [NSRC*8-1:0] vec_flat,
  output logic [NSRC*8-1:0] route_flat
);
  localparam int NW = NSRC / 32;
  localparam int NB = NSRC / 4;
  localparam int WA = AW - 2;

  logic [WA-1:0] wa;
  logic [1:0]    unused_lo;
  assign wa        = addr[AW-1:2];
  assign unused_lo = addr[1:0];

  logic [31:0] ctrl  [NFLD][NW];
  logic [31:0] vec_w [NB];
  logic [31:0] rt_w  [NB];

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    for (genvar w = 0; w < NW; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n) ctrl[f][w] <= '0;
        else if (wr && wa == WA'(fld_base(f) / 4 + w))
          ctrl[f][w] <= be_merge(ctrl[f][w], wdata, be);
      end
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_out
    assign mask[32*w +: 32]       = ctrl[F_MASK][w];
    assign enable[32*w +: 32]     = ctrl[F_EN][w];
    assign edge_mode[32*w +: 32]  = ctrl[F_EDGE][w];
    assign active_low[32*w +: 32] = ctrl[F_POL][w];
    assign clr[32*w +: 32] = (wr && wa == WA'(OFS_CLR / 4 + w)) ?
                             (wdata & lane_mask(be)) : '0;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vec_w[b] <= '0;
        rt_w[b]  <= '0;
      end else if (wr) begin
        if (wa == WA'(OFS_VEC / 4 + b))   vec_w[b] <= be_merge(vec_w[b], wdata, be);
        if (wa == WA'(OFS_ROUTE / 4 + b)) rt_w[b]  <= be_merge(rt_w[b], wdata, be);
      end
    end
    assign vec_flat[32*b +: 32]   = vec_w[b];
    assign route_flat[32*b +: 32] = rt_w[b];
  end

  always_comb begin
    rdata = '0;
    for (int f = 0; f < NFLD; f++)
      for (int w = 0; w < NW; w++)
        if (wa == WA'(fld_base(f) / 4 + w)) rdata = ctrl[f][w];
    for (int b = 0; b < NB; b++) begin
      if (wa == WA'(OFS_VEC / 4 + b))   rdata = vec_w[b];
      if (wa == WA'(OFS_ROUTE / 4 + b)) rdata = rt_w[b];
    end
  end
endmodule

// File: rtl/vmc_src.sv
module vmc_src (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw,
  input  logic edge_mode,
  input  logic active_low,
  input  logic clr,
  input  logic take,
  output logic pend,
  output logic sent
);
  logic s1, s2, s3;
  logic lvl, lvl_prev, hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= irq_raw;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl      = s2 ^ active_low;
  assign lvl_prev = s3 ^ active_low;
  assign hit      = edge_mode ? (lvl & ~lvl_prev) : lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      sent <= 1'b0;
    end else begin
      pend <= hit | (pend & ~clr);
      sent <= clr ? 1'b0 : (sent | take);
    end
  end
endmodule

// File: rtl/vmc_arb.sv
module vmc_arb #(
  parameter int NSRC = 64,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   elig,
  input  logic [NSRC*8-1:0] vec_flat,
  input  logic [NSRC*8-1:0] route_flat,
  input  logic              ready,
  output logic              valid,
  output logic [7:0]        vector,
  output logic [7:0]        route,
  output logic [NSRC-1:0]   take
);
  logic          load, any;
  logic [IW-1:0] pick;

  assign load = !valid || ready;

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any  = 1'b1;
        pick = IW'(i);
      end
    end
  end

  always_comb begin
    take = '0;
    if (load && any) take[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      vector <= '0;
      route  <= '0;
    end else if (load) begin
      valid <= any;
      if (any) begin
        vector <= vec_flat[8*pick +: 8];
        route  <= route_flat[8*pick +: 8];
      end
    end
  end
endmodule

// File: rtl/vmc_top.sv
module vmc_top #(
  parameter int NSRC = 64,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  input  logic [3:0]      reg_be,
  output logic [31:0]     reg_rdata,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [7:0]      msg_vector,
  output logic [7:0]      msg_route
);
  logic [NSRC-1:0]   mask, enable, edge_mode, active_low, clr;
  logic [NSRC-1:0]   pend, sent, elig, take;
  logic [NSRC*8-1:0] vec_flat, route_flat;

  vmc_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .be(reg_be), .rdata(reg_rdata),
    .mask(mask), .enable(enable), .edge_mode(edge_mode),
    .active_low(active_low), .clr(clr),
    .vec_flat(vec_flat), .route_flat(route_flat)
  );

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    vmc_src u_src (
      .clk(clk), .rst_n(rst_n), .irq_raw(irq_in[n]),
      .edge_mode(edge_mode[n]), .active_low(active_low[n]),
      .clr(clr[n]), .take(take[n]), .pend(pend[n]), .sent(sent[n])
    );
  end

  assign elig = pend & ~sent & ~mask & enable;

  vmc_arb #(.NSRC(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig),
    .vec_flat(vec_flat), .route_flat(route_flat),
    .ready(msg_ready), .valid(msg_valid),
    .vector(msg_vector), .route(msg_route), .take(take)
  );
endmodule

// File: rtl/vmc_chk.sv
module vmc_chk #(
  parameter int NSRC = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            msg_valid,
  input logic            msg_ready,
  input logic [7:0]      msg_vector,
  input logic [7:0]      msg_route,
  input logic [NSRC-1:0] take,
  input logic [NSRC-1:0] elig,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] enable
);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_route));

  // R7
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  // R7
  grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take & ~elig) == '0);

  // R8
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take != '0 |-> ((take - NSRC'(1)) & elig) == '0);

  // R2
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take & mask) == '0);

  // R3
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take & ~enable) == '0);
endmodule

bind vmc_top vmc_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_route(msg_route), .take(take),
  .elig(elig), .mask(mask), .enable(enable)
);

// File: tb/sim_vmc_top.sv
module sim_vmc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [7:0]  msg_vector, msg_route;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  vmc_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
    .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_route(msg_route)
  );

  function automatic logic [7:0] exp_vec(input int n);
    return 8'(8'h80 + n);
  endfunction
  function automatic logic [7:0] exp_rt(input int n);
    return 8'(n * 3 + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic [3:0] be = 4'hF);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_msg(input int n, input string tag);
    bit got = 0;
    logic [7:0] v = '0, r = '0;
    for (int i = 0; i < 16 && !got; i++) begin
      @(negedge clk);
      if (msg_valid) begin
        got = 1; v = msg_vector; r = msg_route;
      end
    end
    if (got) begin
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
    end
    check(got, {tag, " message present"}, 32'(got), 1);
    check(v == exp_vec(n), {tag, " vector"}, 32'(v), 32'(exp_vec(n)));
    check(r == exp_rt(n), {tag, " route"}, 32'(r), 32'(exp_rt(n)));
  endtask

  task automatic expect_none(input string tag);
    bit seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
    check(!seen, {tag, " no message"}, 32'(seen), 0);
  endtask

  task automatic clear_all();
    wr(12'h080, 32'hFFFF_FFFF);
    wr(12'h084, 32'hFFFF_FFFF);
  endtask

  // R11
  task automatic t_reset();
    logic [31:0] d;
    check(msg_valid == 1'b0, "R11 valid after reset", 32'(msg_valid), 0);
    rd(12'h020, d); check(d == 0, "R11 mask reset", d, 0);
    rd(12'h044, d); check(d == 0, "R11 enable reset", d, 0);
    rd(12'h200, d); check(d == 0, "R11 vector reset", d, 0);
    rd(12'h13C, d); check(d == 0, "R11 route reset", d, 0);
  endtask

  // R1 R5 R10
  task automatic t_regs();
    logic [31:0] d;
    wr(12'h064, 32'hA5A5_1234, 4'b1100);
    rd(12'h064, d); check(d == 32'hA5A5_0000, "R1 byte enables", d, 32'hA5A5_0000);
    wr(12'h064, 32'hFFFF_FFFF, 4'b0001);
    rd(12'h064, d); check(d == 32'hA5A5_00FF, "R1 lane merge", d, 32'hA5A5_00FF);
    wr(12'h064, 32'h0);
    wr(12'h0C4, 32'hDEAD_BEEF);
    wr(12'h0E0, 32'h1357_9BDF);
    rd(12'h0C4, d); check(d == 32'hDEAD_BEEF, "R10 aux0 readback", d, 32'hDEAD_BEEF);
    rd(12'h0E0, d); check(d == 32'h1357_9BDF, "R10 aux1 readback", d, 32'h1357_9BDF);
    rd(12'h080, d); check(d == 0, "R5 clear reads zero", d, 0);
  endtask

  task automatic setup();
    for (int b = 0; b < 16; b++) begin
      wr(12'(12'h200 + 4*b), {exp_vec(4*b+3), exp_vec(4*b+2), exp_vec(4*b+1), exp_vec(4*b)});
      wr(12'(12'h100 + 4*b), {exp_rt(4*b+3), exp_rt(4*b+2), exp_rt(4*b+1), exp_rt(4*b)});
    end
    wr(12'h040, 32'hFFFF_FFFF);
    wr(12'h044, 32'hFFFF_FFFF);
  endtask

  // R6 R7 R5 R4
  task automatic t_level_high();
    irq_in[5] = 1'b1;
    expect_msg(5, "R6 level-high line 5");
    expect_none("R7 single per pending period");
    wr(12'h080, 32'h0);
    expect_none("R5 zero clear no effect");
    wr(12'h080, 32'h20);
    expect_msg(5, "R7 clear with active level re-arms");
    irq_in[5] = 1'b0;
    idle(4);
    wr(12'h080, 32'h20);
    expect_none("R5 cleared after level drop");
  endtask

  // R2 R5
  task automatic t_mask();
    wr(12'h020, 32'h200);
    irq_in[9] = 1'b1; idle(4); irq_in[9] = 1'b0;
    expect_none("R2 masked line 9");
    wr(12'h020, 32'h0);
    expect_msg(9, "R5 sticky pending after unmask");
    wr(12'h080, 32'h200);
  endtask

  // R3
  task automatic t_enable();
    wr(12'h044, 32'hFFFF_FEFF);
    irq_in[40] = 1'b1;
    expect_none("R3 disabled line 40");
    wr(12'h044, 32'hFFFF_FFFF);
    expect_msg(40, "R3 enabled line 40");
    irq_in[40] = 1'b0; idle(4);
    wr(12'h084, 32'h100);
  endtask

  // R4
  task automatic t_modes();
    wr(12'h020, 32'h0010_0000);
    wr(12'h3E0, 32'h0010_0000);
    wr(12'h060, 32'h0000_1000);
    wr(12'h064, 32'h0004_0000);
    wr(12'h3E4, 32'h0004_0000);
    irq_in[20] = 1'b1;
    idle(4);
    clear_all();
    wr(12'h020, 32'h0);
    expect_none("R4 quiet after mode setup");
    irq_in[12] = 1'b1;
    expect_msg(12, "R4 rising edge line 12");
    wr(12'h080, 32'h1000);
    expect_none("R4 edge line held high no retrigger");
    irq_in[12] = 1'b0;
    expect_none("R4 rising line ignores fall");
    irq_in[50] = 1'b1;
    expect_none("R4 falling line ignores rise");
    irq_in[50] = 1'b0;
    expect_msg(50, "R4 falling edge line 50");
    irq_in[20] = 1'b0;
    expect_msg(20, "R4 level-low line 20");
    irq_in[20] = 1'b1; idle(4);
    wr(12'h080, 32'h0010_0000);
    expect_none("R4 level-low inactive after clear");
  endtask

  // R8 R9 R10
  task automatic t_prio();
    bit stable = 1;
    wr(12'h0C0, 32'hFFFF_FFFF);
    wr(12'h0E4, 32'hFFFF_FFFF);
    irq_in[40] = 1'b1; irq_in[33] = 1'b1; irq_in[3] = 1'b1;
    idle(8);
    check(msg_valid == 1'b1, "R8 valid with three lines", 32'(msg_valid), 1);
    check(msg_vector == exp_vec(3), "R8 lowest first", 32'(msg_vector), 32'(exp_vec(3)));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!msg_valid || msg_vector != exp_vec(3) || msg_route != exp_rt(3)) stable = 0;
    end
    check(stable, "R9 held under back-pressure", 32'(stable), 1);
    expect_msg(3, "R8 first");
    expect_msg(33, "R8 second");
    expect_msg(40, "R8 third");
    expect_none("R10 aux fields cause no resend");
    irq_in[40] = 1'b0; irq_in[33] = 1'b0; irq_in[3] = 1'b0;
    idle(4);
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_regs();
    setup();
    t_level_high();
    t_mask();
    t_enable();
    t_modes();
    t_prio();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule